// File: doc/BRIEF.md
# Differential Clock Stop Controller

This block sits between a clock source and eight differential output pairs. Each pair has a true output, a complement output and a drive enable. A global active-low stop pin, which may change at any time, halts the lanes that are marked stoppable. Lanes that are not marked keep running. The block never cuts a pulse short. A halted lane holds its true side high. Depending on a mode bit, the halted lane is either still driven or released to high impedance.

When the stop pin is released, each halted lane first drives its true side high. After a fixed number of clock periods it rejoins the clock on a low phase, so no runt pulse appears.

Each lane's drive enable combines a register bit with an enable pin. A polarity bit decides whether the enable pins are active high or active low.

All state changes on the falling edge of the clock. The stop pin passes through a two-flop synchronizer before any lane acts on it. `RESUME_CYC` (at least 2) sets the wait from the synchronized release to the first toggle.

Top module: `dif_stop_ctrl`

## Requirements
- R1: While `rst_n` is low every `clk_oe` bit is 0. From the first falling edge after reset release, every enabled lane drives and `clk_t` follows the clock.
- R2: A lane's enable is `cfg_en[i]` AND (`oe_pin[i]` equals `cfg_oe_act_high`): a polarity bit of 1 makes the pins active high, and 0 makes them active low. A lane whose enable is 0 has `clk_oe` 0.
- R3: A lane whose `cfg_stoppable` bit is 0 keeps toggling for as long as `stop_n` is low.
- R4: Let n0 be the first falling edge that sees `stop_n` low. A stoppable lane still toggles in the low phase after edge n0+1. From edge n0+2 its `clk_t` is held high, so its last high phase is always complete.
- R5: With `cfg_park_hiz` = 0, a held lane shows `clk_t` = 1 and `clk_c` = 0, and its `clk_oe` still equals its enable.
- R6: With `cfg_park_hiz` = 1, a held lane has `clk_oe` = 0.
- R7: Let n0 be the first falling edge that sees `stop_n` high again. From edge n0+2 a held lane drives `clk_t` high with `clk_oe` equal to its enable. From edge n0+1+RESUME_CYC it toggles again. With the default of 2 this means it runs again 3 to 4 periods after the pin changes.
- R8: `clk_c` is always the inverse of `clk_t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock that is gated to the lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| oe_pin | input | N_OUT | Per-lane enable pins, polarity set by `cfg_oe_act_high` |
| cfg_en | input | N_OUT | Per-lane register enable |
| cfg_stoppable | input | N_OUT | 1 = lane obeys `stop_n`, 0 = lane runs freely |
| cfg_oe_act_high | input | 1 | 1 = enable pins active high, 0 = active low |
| cfg_park_hiz | input | 1 | 0 = held lanes stay driven, 1 = held lanes go high impedance |
| clk_t | output | N_OUT | True side of each lane |
| clk_c | output | N_OUT | Complement side of each lane |
| clk_oe | output | N_OUT | Drive enable of each lane |

## Verification
The assertions check on every cycle that a lane is never driven while its enable is off, and that free-running lanes never become held. They also check that, once the stop pin has been low for the synchronizer latency, every stoppable lane is held, and that in high-impedance mode those lanes are not driven. Finally, they check that no lane is still held once the stop pin has been high for longer than the resume window. The exact edges at which a lane parks, leaves high impedance and toggles again can only be shown by the bench's scenarios. So can the level of the true and complement outputs in each clock phase. The bench samples these in the middle of both clock phases across several stoppable patterns and both drive modes.

// File: rtl/dstop_pkg.sv
package dstop_pkg;
    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_RUN  = 2'd1,
        LANE_HOLD = 2'd2,
        LANE_WAKE = 2'd3
    } lane_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_regs_t;
endpackage

// File: rtl/dstop_sync.sv
module dstop_sync
    import dstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic stop_req
);
    sync_regs_t r_d, r_q;

    always_comb begin
        r_d.s1 = async_n;
        r_d.s2 = r_q.s1;
    end

    // falling-edge flops: same edge as the lane state
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1};
        else        r_q <= r_d;
    end

    assign stop_req = ~r_q.s2;
endmodule

// File: rtl/dstop_resume.sv
module dstop_resume #(
    parameter int RESUME_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    output logic resume_ok
);
    localparam int CNT_W = (RESUME_CYC > 2) ? $clog2(RESUME_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RESUME_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (stop_req)            cnt_d = '0;
        else if (cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign resume_ok = ~stop_req & (cnt_q == LAST);
endmodule

// File: rtl/dstop_lane.sv
module dstop_lane
    import dstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic resume_ok,
    input  logic stoppable,
    input  logic enable,
    input  logic park_hiz,
    output logic out_t,
    output logic out_c,
    output logic out_oe,
    output logic held
);
    lane_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LANE_OFF:  st_d = LANE_RUN;
            LANE_RUN:  if (stop_req && stoppable) st_d = LANE_HOLD;
            LANE_HOLD: if (!stop_req) st_d = LANE_WAKE;
            LANE_WAKE: begin
                if (stop_req)       st_d = LANE_HOLD;
                else if (resume_ok) st_d = LANE_RUN;
            end
            default:   st_d = LANE_OFF;
        endcase
    end

    // state moves only while the clock is low: a hold extends a high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            LANE_RUN:  begin out_t = clk;  out_oe = enable;             end
            LANE_HOLD: begin out_t = 1'b1; out_oe = enable & ~park_hiz; end
            LANE_WAKE: begin out_t = 1'b1; out_oe = enable;             end
            default:   begin out_t = 1'b0; out_oe = 1'b0;               end
        endcase
    end

    assign out_c = ~out_t;
    assign held  = (st_q == LANE_HOLD) || (st_q == LANE_WAKE);
endmodule

// File: rtl/dif_stop_ctrl.sv
module dif_stop_ctrl #(
    parameter int N_OUT      = 8,
    parameter int RESUME_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_n,
    input  logic [N_OUT-1:0] oe_pin,
    input  logic [N_OUT-1:0] cfg_en,
    input  logic [N_OUT-1:0] cfg_stoppable,
    input  logic             cfg_oe_act_high,
    input  logic             cfg_park_hiz,
    output logic [N_OUT-1:0] clk_t,
    output logic [N_OUT-1:0] clk_c,
    output logic [N_OUT-1:0] clk_oe
);
    logic             stop_req;
    logic             resume_ok;
    logic [N_OUT-1:0] lane_en;
    logic [N_OUT-1:0] lane_held;

    dstop_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_n  (stop_n),
        .stop_req (stop_req)
    );

    dstop_resume #(.RESUME_CYC(RESUME_CYC)) u_resume (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_req  (stop_req),
        .resume_ok (resume_ok)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        assign lane_en[i] = cfg_en[i] & ~(oe_pin[i] ^ cfg_oe_act_high);

        dstop_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .stop_req  (stop_req),
            .resume_ok (resume_ok),
            .stoppable (cfg_stoppable[i]),
            .enable    (lane_en[i]),
            .park_hiz  (cfg_park_hiz),
            .out_t     (clk_t[i]),
            .out_c     (clk_c[i]),
            .out_oe    (clk_oe[i]),
            .held      (lane_held[i])
        );
    end
endmodule

// File: rtl/dif_stop_ctrl_chk.sv
module dif_stop_ctrl_chk #(
    parameter int N_OUT      = 8,
    parameter int RESUME_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_n,
    input logic [N_OUT-1:0] oe_pin,
    input logic [N_OUT-1:0] cfg_en,
    input logic [N_OUT-1:0] cfg_stoppable,
    input logic             cfg_oe_act_high,
    input logic             cfg_park_hiz,
    input logic [N_OUT-1:0] clk_oe,
    input logic [N_OUT-1:0] lane_held
);
    localparam int LIM = RESUME_CYC + 3;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0]    lo_cnt_q, hi_cnt_q;
    logic [N_OUT-1:0] eff_en;

    assign eff_en = cfg_en & ~(oe_pin ^ {N_OUT{cfg_oe_act_high}});

    // consecutive rising-edge samples of the stop pin at each level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else begin
            lo_cnt_q <= stop_n ? '0 : ((int'(lo_cnt_q) < LIM) ? lo_cnt_q + 1'b1 : lo_cnt_q);
            hi_cnt_q <= !stop_n ? '0 : ((int'(hi_cnt_q) < LIM) ? hi_cnt_q + 1'b1 : hi_cnt_q);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_hiz: assert (clk_oe == '0);
        end
    end

    a_r2_disabled_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe & ~eff_en) == '0);

    a_r3_free_lane_never_held: assert property (@(posedge clk) disable iff (!rst_n)
        (~$past(lane_held) & ~cfg_stoppable & ~$past(cfg_stoppable) & lane_held) == '0);

    a_r4_stoppable_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && int'(lo_cnt_q) >= 3 && cfg_stoppable == $past(cfg_stoppable))
        |-> ((cfg_stoppable & ~lane_held) == '0));

    a_r5_held_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_park_hiz |-> ((lane_held & eff_en & ~clk_oe) == '0));

    a_r6_held_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_park_hiz && !stop_n && int'(lo_cnt_q) >= 3 && cfg_stoppable == $past(cfg_stoppable))
        |-> ((cfg_stoppable & clk_oe) == '0));

    a_r7_resume_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_n && int'(hi_cnt_q) >= RESUME_CYC + 2) |-> (lane_held == '0));
endmodule

bind dif_stop_ctrl dif_stop_ctrl_chk #(.N_OUT(N_OUT), .RESUME_CYC(RESUME_CYC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stop_n          (stop_n),
    .oe_pin          (oe_pin),
    .cfg_en          (cfg_en),
    .cfg_stoppable   (cfg_stoppable),
    .cfg_oe_act_high (cfg_oe_act_high),
    .cfg_park_hiz    (cfg_park_hiz),
    .clk_oe          (clk_oe),
    .lane_held       (lane_held)
);

// File: tb/sim_dif_stop_ctrl.sv
module sim_dif_stop_ctrl;
    localparam int RES = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_n = 1'b1;
    logic [7:0] oe_pin = 8'hFF;
    logic [7:0] cfg_en = 8'hFF;
    logic [7:0] cfg_st = 8'h00;
    logic       pol = 1'b1;
    logic       hiz = 1'b0;
    logic [7:0] t, c, oe;

    int n_chk  = 0;
    int n_fail = 0;

    dif_stop_ctrl #(.N_OUT(8), .RESUME_CYC(RES)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .stop_n          (stop_n),
        .oe_pin          (oe_pin),
        .cfg_en          (cfg_en),
        .cfg_stoppable   (cfg_st),
        .cfg_oe_act_high (pol),
        .cfg_park_hiz    (hiz),
        .clk_t           (t),
        .clk_c           (c),
        .clk_oe          (oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic low_phase();
        @(negedge clk); #2;
    endtask

    task automatic high_phase();
        @(posedge clk); #2;
    endtask

    task automatic run_case(input logic hz, input logic [7:0] pat);
        logic [7:0] park_oe;
        park_oe = hz ? ~pat : 8'hFF;
        @(posedge clk); #1;
        hiz = hz;
        cfg_st = pat;
        low_phase();  chk("R3 running before stop, low phase", t, 8'h00);
        high_phase(); chk("R3 running before stop, high phase", t, 8'hFF);
        @(posedge clk); #1 stop_n = 1'b0;
        low_phase();  chk("R4 edge n0 still toggling", t, 8'h00);
        low_phase();  chk("R4 edge n0+1 still toggling", t, 8'h00);
        low_phase();
        chk("R4 held at edge n0+2", t, pat);
        chk("R8 complement of held", c, ~pat);
        chk(hz ? "R6 held lanes undriven" : "R5 held lanes driven", oe, park_oe);
        high_phase(); chk("R4 high phase while held", t, 8'hFF);
        low_phase();  chk("R3 free lanes still toggle", t, pat);
        @(posedge clk); #1 stop_n = 1'b1;
        low_phase();  chk("R7 edge n0 still held", t, pat);
        low_phase();
        chk("R7 edge n0+1 still held", t, pat);
        chk("R7 edge n0+1 drive state", oe, park_oe);
        for (int k = 2; k <= RES; k++) begin
            low_phase();
            chk("R7 waking lanes drive high", t, pat);
            chk("R7 waking lanes enabled", oe, 8'hFF);
        end
        low_phase();
        chk("R7 toggling resumed", t, 8'h00);
        chk("R7 enabled after resume", oe, 8'hFF);
        high_phase();
        chk("R7 high phase after resume", t, 8'hFF);
        chk("R8 complement after resume", c, 8'h00);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        logic [7:0] pins [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
        pins[0] = 8'hAA; pins[1] = 8'h55; pins[2] = 8'h00; pins[3] = 8'hFF;

        repeat (3) @(posedge clk);
        #2 chk("R1 undriven during reset", oe, 8'h00);
        @(posedge clk); #1 rst_n = 1'b1;
        low_phase();
        chk("R1 driven after release", oe, 8'hFF);
        chk("R1 toggling low phase", t, 8'h00);
        high_phase();
        chk("R1 toggling high phase", t, 8'hFF);
        chk("R8 complement running", c, 8'h00);

        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p < 4; p++) begin
                run_case(h[0], pats[p]);
            end
        end

        cfg_en = 8'hCC;
        for (int pl = 0; pl < 2; pl++) begin
            for (int q = 0; q < 4; q++) begin
                @(posedge clk); #1;
                pol = pl[0];
                oe_pin = pins[q];
                #2 chk("R2 enable pin polarity", oe, cfg_en & ~(pins[q] ^ {8{pl[0]}}));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule